// File: doc/BRIEF.md
# Dual-Bus Post-Modify Address Generator

This block produces two word addresses in the same cycle, one for an X-side data memory and one for a Y-side data memory. Each side owns two pointer registers and one index register. The caller selects a pointer on each side. The selected pointer is presented as the address in that cycle. At the following clock edge the pointer is updated by one of three rules: it is left unchanged, 2 is added to it, or the index register of that side is added to it.

The X side can also run as a circular buffer. When the wrap enable is set, an updated X pointer that lands exactly on the programmed end address is replaced by the programmed start address. A single register-write port loads any of the pointers, the indexes and the buffer bounds. The updated pointer of each side is also driven out as a write-back value with a strobe, so that a surrounding register file can mirror it.

Top module: `agen_dualbus`

## Requirements
- R1: While reset is asserted, and after it is released, every pointer, index, start and end register holds zero, so both addresses read zero for either select value.
- R2: `xAddr` shows X pointer `xSel` (0 or 1) and `yAddr` shows Y pointer `ySel`. Both are combinational and always have bit 0 forced to zero.
- R3: Mode code 2'b01 with the side enabled drives the old pointer as the address in that cycle. The pointer becomes the aligned old value plus 2 from the next cycle on.
- R4: Mode code 2'b10 with the side enabled adds that side's index register (bit 0 cleared), modulo 2^AW, after the access.
- R5: Mode codes 2'b00 and 2'b11, or a disabled side, leave the pointer unchanged and hold the write-back strobe low.
- R6: The X and Y sides update in the same cycle, independently of each other.
- R7: With `modEn` high, an X update whose result equals the aligned end register loads the aligned start register instead. The Y side never wraps.
- R8: A register write lands at the same edge as any update. If it targets the pointer being updated, the written value wins and is seen by the next access.
- R9: `xWbEn`/`yWbEn` are high exactly when that side updates, and `xWbData`/`yWbData` carry the new pointer value, after any wrap.
- R10: Write codes on `wrSel`: 0 = X pointer 0, 1 = X pointer 1, 2 = Y pointer 0, 3 = Y pointer 1, 4 = X index, 5 = Y index, 6 = wrap start, 7 = wrap end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register write target code |
| wrData | input | AW | Register write value |
| xEn | input | 1 | X access enable |
| xSel | input | 1 | X pointer select |
| xMode | input | 2 | X update mode |
| yEn | input | 1 | Y access enable |
| ySel | input | 1 | Y pointer select |
| yMode | input | 2 | Y update mode |
| modEn | input | 1 | X circular-buffer enable |
| xAddr | output | AW | X word address |
| yAddr | output | AW | Y word address |
| xWbEn | output | 1 | X pointer write-back strobe |
| xWbData | output | AW | Updated X pointer |
| yWbEn | output | 1 | Y pointer write-back strobe |
| yWbData | output | AW | Updated Y pointer |

## Verification
The hardest case to reach is a circular-buffer reload that coincides with the other side advancing past the same end address. Reaching it takes the start and end bounds, an X pointer, and a Y pointer one step behind that end, all loaded through the write port. Both sides then increment together with `modEn` high, so the X pointer folds back while the Y pointer runs past the end. A second hard case is a write that collides with an update of the same pointer. The bench lines up the write and the increment at one edge and reads the address on the next cycle.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int NREG = 8;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_INC2 = 2'b01,
    MODE_IDX  = 2'b10,
    MODE_RSVD = 2'b11
  } updMode_e;

  typedef enum logic [2:0] {
    REG_X0    = 3'd0,
    REG_X1    = 3'd1,
    REG_Y0    = 3'd2,
    REG_Y1    = 3'd3,
    REG_XIDX  = 3'd4,
    REG_YIDX  = 3'd5,
    REG_START = 3'd6,
    REG_END   = 3'd7
  } regCode_e;

  typedef struct packed {
    logic            xUpd;
    logic            xIdx;
    logic            xSel;
    logic            yUpd;
    logic            yIdx;
    logic            ySel;
    logic            wrap;
    logic [NREG-1:0] wrHot;
  } agenStrobe_t;
endpackage

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import agen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrSel,
  input  logic        xEn,
  input  logic        xSel,
  input  logic [1:0]  xMode,
  input  logic        yEn,
  input  logic        ySel,
  input  logic [1:0]  yMode,
  input  logic        modEn,
  output agenStrobe_t st
);
  logic [NREG-1:0] wrDec;

  generate
    for (genvar g = 0; g < NREG; g++) begin : gDec
      assign wrDec[g] = wrEn && (wrSel == 3'(g));
    end
  endgenerate

  always_comb begin
    st       = '0;
    st.xSel  = xSel;
    st.ySel  = ySel;
    st.xUpd  = xEn && (xMode == MODE_INC2 || xMode == MODE_IDX);
    st.xIdx  = xMode == MODE_IDX;
    st.yUpd  = yEn && (yMode == MODE_INC2 || yMode == MODE_IDX);
    st.yIdx  = yMode == MODE_IDX;
    st.wrap  = modEn;
    st.wrHot = wrDec;
  end

  // R10: one register at most is written per cycle
  assert_single_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(st.wrHot));
endmodule

// File: rtl/agen_dp.sv
module agen_dp
  import agen_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  agenStrobe_t   st,
  input  logic [AW-1:0] wrData,
  output logic [AW-1:0] xAddr,
  output logic [AW-1:0] yAddr,
  output logic [AW-1:0] xNext,
  output logic [AW-1:0] yNext
);
  localparam logic [AW-1:0] STEP  = AW'(2);
  localparam logic [AW-1:0] ALIGN = ~AW'(1);

  logic [AW-1:0] xPtr [2];
  logic [AW-1:0] yPtr [2];
  logic [AW-1:0] xIdxReg, yIdxReg, startReg, endReg;
  logic [AW-1:0] xBase, yBase, xSum, ySum;

  assign xBase = xPtr[st.xSel] & ALIGN;
  assign yBase = yPtr[st.ySel] & ALIGN;
  assign xAddr = xBase;
  assign yAddr = yBase;

  always_comb begin
    xSum  = xBase + (st.xIdx ? (xIdxReg & ALIGN) : STEP);
    ySum  = yBase + (st.yIdx ? (yIdxReg & ALIGN) : STEP);
    xNext = (st.wrap && xSum == (endReg & ALIGN)) ? (startReg & ALIGN) : xSum;
    yNext = ySum;
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : gPtr
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          xPtr[g] <= '0;
          yPtr[g] <= '0;
        end else begin
          if (st.wrHot[REG_X0 + g])
            xPtr[g] <= wrData;
          else if (st.xUpd && st.xSel == 1'(g))
            xPtr[g] <= xNext;
          if (st.wrHot[REG_Y0 + g])
            yPtr[g] <= wrData;
          else if (st.yUpd && st.ySel == 1'(g))
            yPtr[g] <= yNext;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xIdxReg  <= '0;
      yIdxReg  <= '0;
      startReg <= '0;
      endReg   <= '0;
    end else begin
      if (st.wrHot[REG_XIDX])  xIdxReg  <= wrData;
      if (st.wrHot[REG_YIDX])  yIdxReg  <= wrData;
      if (st.wrHot[REG_START]) startReg <= wrData;
      if (st.wrHot[REG_END])   endReg   <= wrData;
    end
  end

  // R5: an idle X pointer keeps its value
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!(st.xUpd && !st.xSel) && !st.wrHot[REG_X0]) |=> xPtr[0] == $past(xPtr[0]));

  // R8: a write overrides any same-cycle update
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.wrHot[REG_X0] |=> xPtr[0] == $past(wrData));

  // R3: plain post-increment on X pointer 0 without wrap
  assert_post_inc_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.xUpd && !st.xIdx && !st.wrap && !st.xSel && !st.wrHot[REG_X0])
      |=> xPtr[0] == $past(xBase) + STEP);

  // R6: Y pointer 1 advances on its own regardless of the X side
  assert_y_inc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st.yUpd && !st.yIdx && st.ySel && !st.wrHot[REG_Y1])
      |=> yPtr[1] == $past(yBase) + STEP);
endmodule

// File: rtl/agen_dualbus.sv
module agen_dualbus
  import agen_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    wrSel,
  input  logic [AW-1:0] wrData,
  input  logic          xEn,
  input  logic          xSel,
  input  logic [1:0]    xMode,
  input  logic          yEn,
  input  logic          ySel,
  input  logic [1:0]    yMode,
  input  logic          modEn,
  output logic [AW-1:0] xAddr,
  output logic [AW-1:0] yAddr,
  output logic          xWbEn,
  output logic [AW-1:0] xWbData,
  output logic          yWbEn,
  output logic [AW-1:0] yWbData
);
  agenStrobe_t st;

  agen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .xEn(xEn), .xSel(xSel), .xMode(xMode),
    .yEn(yEn), .ySel(ySel), .yMode(yMode),
    .modEn(modEn), .st(st)
  );

  agen_dp #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData),
    .xAddr(xAddr), .yAddr(yAddr), .xNext(xWbData), .yNext(yWbData)
  );

  assign xWbEn = st.xUpd;
  assign yWbEn = st.yUpd;

  // R2: word alignment on both buses
  always_comb begin
    if (rstN) begin
      assert_align_R2: assert (xAddr[0] == 1'b0 && yAddr[0] == 1'b0);
    end
  end
endmodule

// File: tb/agen_dualbus_tb.sv
module agen_dualbus_tb;
  localparam int AW = 16;

  logic          clk = 0;
  logic          rstN = 0;
  logic          wrEn = 0;
  logic [2:0]    wrSel = 0;
  logic [AW-1:0] wrData = 0;
  logic          xEn = 0, xSel = 0, yEn = 0, ySel = 0, modEn = 0;
  logic [1:0]    xMode = 0, yMode = 0;
  logic [AW-1:0] xAddr, yAddr, xWbData, yWbData;
  logic          xWbEn, yWbEn;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  agen_dualbus #(.AW(AW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .xEn(xEn), .xSel(xSel), .xMode(xMode), .yEn(yEn), .ySel(ySel), .yMode(yMode),
    .modEn(modEn), .xAddr(xAddr), .yAddr(yAddr), .xWbEn(xWbEn), .xWbData(xWbData),
    .yWbEn(yWbEn), .yWbData(yWbData)
  );

  task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; xEn = 0; yEn = 0; xMode = 0; yMode = 0; modEn = 0;
  endtask

  task automatic wr(input logic [2:0] code, input logic [AW-1:0] d);
    @(negedge clk);
    idle();
    wrEn = 1; wrSel = code; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic test_reset();
    xSel = 0; ySel = 0; #1;
    chk("R1 x0", xAddr, 0); chk("R1 y0", yAddr, 0);
    xSel = 1; ySel = 1; #1;
    chk("R1 x1", xAddr, 0); chk("R1 y1", yAddr, 0);
  endtask

  task automatic test_select();
    wr(0, 16'h1000); wr(1, 16'h2001); wr(2, 16'h3000); wr(3, 16'h3801);
    xSel = 0; ySel = 0; #1;
    chk("R10 x0", xAddr, 16'h1000); chk("R10 y0", yAddr, 16'h3000);
    xSel = 1; ySel = 1; #1;
    chk("R2 x1 aligned", xAddr, 16'h2000); chk("R2 y1 aligned", yAddr, 16'h3800);
  endtask

  task automatic test_inc();
    @(negedge clk);
    xEn = 1; xSel = 0; xMode = 2'b01; #1;
    chk("R3 addr old", xAddr, 16'h1000);
    chk("R9 wb en", 16'(xWbEn), 1); chk("R9 wb data", xWbData, 16'h1002);
    @(negedge clk); idle(); #1;
    chk("R3 addr new", xAddr, 16'h1002);
  endtask

  task automatic test_index_parallel();
    wr(4, 16'h0011); wr(5, 16'hFFFE);
    @(negedge clk);
    xEn = 1; xSel = 0; xMode = 2'b10; yEn = 1; ySel = 0; yMode = 2'b10;
    @(negedge clk); idle(); xSel = 0; ySel = 0; #1;
    chk("R4 x idx", xAddr, 16'h1012);
    chk("R6 y idx", yAddr, 16'h2FFE);
  endtask

  task automatic test_hold();
    @(negedge clk);
    xEn = 1; xSel = 0; xMode = 2'b00; yEn = 1; ySel = 0; yMode = 2'b11; #1;
    chk("R5 wb x low", 16'(xWbEn), 0); chk("R5 wb y low", 16'(yWbEn), 0);
    @(negedge clk);
    xEn = 0; xMode = 2'b01; #1;
    @(negedge clk); idle(); #1;
    chk("R5 x hold", xAddr, 16'h1012); chk("R5 y hold", yAddr, 16'h2FFE);
  endtask

  task automatic test_wrap();
    wr(6, 16'h4000); wr(7, 16'h4004); wr(1, 16'h4000); wr(3, 16'h4002);
    @(negedge clk);
    modEn = 1; xEn = 1; xSel = 1; xMode = 2'b01; yEn = 1; ySel = 1; yMode = 2'b01;
    @(negedge clk); #1;
    chk("R7 x step", xAddr, 16'h4002);
    chk("R7 y past end", yAddr, 16'h4004);
    chk("R9 wrapped wb", xWbData, 16'h4000);
    @(negedge clk); idle(); #1;
    chk("R7 x reload", xAddr, 16'h4000);
    chk("R7 y no wrap", yAddr, 16'h4006);
  endtask

  task automatic test_collide();
    @(negedge clk);
    xEn = 1; xSel = 0; xMode = 2'b01;
    wrEn = 1; wrSel = 0; wrData = 16'h5550;
    @(negedge clk); idle(); xSel = 0; #1;
    chk("R8 write wins", xAddr, 16'h5550);
    @(negedge clk);
    xEn = 1; xSel = 0; xMode = 2'b01;
    wrEn = 1; wrSel = 1; wrData = 16'h6000;
    @(negedge clk); idle(); #1;
    chk("R8 other upd", xAddr, 16'h5552);
    xSel = 1; #1;
    chk("R8 other wr", xAddr, 16'h6000);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1;
    @(negedge clk);
    test_reset();
    test_select();
    test_inc();
    test_index_parallel();
    test_hold();
    test_wrap();
    test_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule